// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is an I2C target that serves a byte-wide memory held in a register array inside the block. By default the array is 512 bytes, and it can be built as 256 bytes. A fast system clock drives every flop in the block. The bus lines are sampled through a synchronizer, and the edges of the sampled SCL mark where bits are taken in and given out. SDA is driven only through an open-drain enable: a high `sda_oe` pulls the line low.

A bus master selects the block with a 7-bit target address followed by a direction bit. The master can then:

- write one byte;
- write a run of bytes that wraps inside a 16-byte page;
- read from the current address counter;
- do a random read: set the address with a write, then issue a repeated START with the read bit set.

Reads advance the counter across the whole array. A lock input blocks writes to the upper half of the memory, and blocked bytes are still acknowledged.

Top module: `serial_mem_target`

## Requirements
- R1: A target address byte is accepted only when its upper nibble is 4'b1010 and its pin slots match `addr_pins`. On any other byte the block gives no acknowledge and keeps `sda_oe` low until the next START.
- R2: In the 512-byte build, bits 3 and 2 of the address byte must match `addr_pins[2]` and `addr_pins[1]`. Bit 1 becomes memory address bit 8 when a word address is loaded. In the 256-byte build, bits 3 to 1 must match `addr_pins[2:0]`.
- R3: The block acknowledges a matching address byte, the word-address byte and every data byte it receives by pulling SDA low for the whole 9th SCL clock. `sda_oe` only changes while SCL is low.
- R4: A write sequence stores each data byte at the current word address. The word address is bit 0 (the direction bit) of the address byte equal to 0, then one byte holding address bits 7:0.
- R5: During a write, only the low 4 address bits advance after each byte. A page write therefore wraps from the last byte of a 16-byte page to the first byte of the same page, and other pages are left unchanged.
- R6: While `wr_lock` is high, writes to addresses whose top bit is 1 leave the memory unchanged but are still acknowledged. Writes to the lower half still take effect.
- R7: A read (direction bit 1) sends the byte at the address counter MSB first, then advances the counter. The block keeps sending bytes while the master acknowledges. A later current-address read continues from where the counter stopped.
- R8: During reads the address counter wraps from the last byte of the array to address 0.
- R9: A START, including a repeated START in the middle of a transfer, restarts address decoding. A write that sets the address, followed by a repeated START with the read bit, reads from that address.
- R10: After a master NoACK the block releases SDA, and after any STOP it leaves the bus. `sda_oe` is low in the cycle after a START or STOP is detected.
- R11: After reset `sda_oe` is low, the address counter is 0 and every memory byte reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock as seen on the wire |
| sda_in | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| addr_pins | input | 3 | Board-strapped target address pins |
| wr_lock | input | 1 | When high, blocks writes to the upper half of memory |

## Verification
The assertions assume a bus master that keeps SCL low for several system clocks after each falling edge. The block moves `sda_oe` a few synchronizer cycles after it detects that edge, and the check that `sda_oe` only moves while SCL is low depends on this. The assertions also assume that `wr_lock` only changes while no write is in flight. The stimulus holds every SCL phase for eight system clocks and changes the master's SDA only while SCL is low, except at START and STOP. It changes `wr_lock` only between transfers, with the bus idle.

// File: rtl/sm_pkg.sv
package sm_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_RX      = 3'd1,
        PH_ACK_OUT = 3'd2,
        PH_TX      = 3'd3,
        PH_ACK_IN  = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        K_DEV  = 2'd0,
        K_WORD = 2'd1,
        K_DATA = 2'd2
    } kind_e;

    localparam logic [3:0] TARGET_NIBBLE = 4'b1010;

endpackage

// File: rtl/sm_line_sync.sv
module sm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.scl_pipe = {s_q.scl_pipe[STAGES-2:0], scl_in};
        s_d.sda_pipe = {s_q.sda_pipe[STAGES-2:0], sda_in};
        s_d.scl_prev = s_q.scl_pipe[STAGES-1];
        s_d.sda_prev = s_q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{scl_pipe: '1, sda_pipe: '1, scl_prev: 1'b1, sda_prev: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_s     = s_q.scl_pipe[STAGES-1];
    assign sda_s     = s_q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~s_q.scl_prev;
    assign scl_fall  = ~scl_s & s_q.scl_prev;
    assign start_evt = scl_s & s_q.scl_prev & s_q.sda_prev & ~sda_s;
    assign stop_evt  = scl_s & s_q.scl_prev & ~s_q.sda_prev & sda_s;

endmodule

// File: rtl/sm_store.sv
module sm_store #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells_q[i] <= '0;
            end
        end else if (we) begin
            cells_q[addr] <= wdata;
        end
    end

    assign rdata = cells_q[addr];

endmodule

// File: rtl/sm_ctrl.sv
module sm_ctrl
    import sm_pkg::*;
#(
    parameter int AW        = 9,
    parameter int PAGE_BITS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_evt,
    input  logic          stop_evt,
    input  logic [2:0]    addr_pins,
    input  logic          wr_lock,
    input  logic [7:0]    rd_data,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          sda_oe,
    output phase_e        phase
);
    localparam bit WIDE = (AW > 8);

    typedef struct packed {
        phase_e        ph;
        kind_e         kind;
        logic [2:0]    cnt;
        logic          full;
        logic [7:0]    sh;
        logic [7:0]    tx;
        logic [AW-1:0] addr;
        logic          hi;
        logic          rd;
        logic          mack;
        logic          oe;
    } ctl_t;

    ctl_t c_d, c_q;

    logic          pin_match;
    logic [AW-1:0] word_addr;
    logic          locked;

    generate
        if (WIDE) begin : g_wide
            assign pin_match = (c_q.sh[7:4] == TARGET_NIBBLE) &&
                               (c_q.sh[3:2] == addr_pins[2:1]);
        end else begin : g_narrow
            assign pin_match = (c_q.sh[7:4] == TARGET_NIBBLE) &&
                               (c_q.sh[3:1] == addr_pins);
        end
    endgenerate

    always_comb begin
        word_addr = AW'(c_q.sh);
        if (WIDE) begin
            word_addr[AW-1] = c_q.hi;
        end
    end

    assign locked = wr_lock && c_q.addr[AW-1];

    always_comb begin
        c_d       = c_q;
        mem_we    = 1'b0;
        if (stop_evt) begin
            c_d.ph = PH_IDLE;
            c_d.oe = 1'b0;
        end else if (start_evt) begin
            c_d.ph   = PH_RX;
            c_d.kind = K_DEV;
            c_d.cnt  = '0;
            c_d.full = 1'b0;
            c_d.oe   = 1'b0;
        end else begin
            unique case (c_q.ph)
                PH_RX: begin
                    if (scl_rise && !c_q.full) begin
                        c_d.sh  = {c_q.sh[6:0], sda_s};
                        c_d.cnt = c_q.cnt + 3'd1;
                        if (c_q.cnt == 3'd7) begin
                            c_d.full = 1'b1;
                        end
                    end else if (scl_fall && c_q.full) begin
                        c_d.full = 1'b0;
                        unique case (c_q.kind)
                            K_DEV: begin
                                if (pin_match) begin
                                    c_d.rd = c_q.sh[0];
                                    c_d.hi = WIDE ? c_q.sh[1] : 1'b0;
                                    c_d.ph = PH_ACK_OUT;
                                    c_d.oe = 1'b1;
                                end else begin
                                    c_d.ph = PH_IDLE;
                                end
                            end
                            K_WORD: begin
                                c_d.addr = word_addr;
                                c_d.ph   = PH_ACK_OUT;
                                c_d.oe   = 1'b1;
                            end
                            default: begin
                                mem_we = !locked;
                                c_d.addr[PAGE_BITS-1:0] = c_q.addr[PAGE_BITS-1:0] + 1'b1;
                                c_d.ph = PH_ACK_OUT;
                                c_d.oe = 1'b1;
                            end
                        endcase
                    end
                end
                PH_ACK_OUT: begin
                    if (scl_fall) begin
                        c_d.cnt = '0;
                        if (c_q.rd) begin
                            c_d.tx   = rd_data;
                            c_d.addr = c_q.addr + 1'b1;
                            c_d.oe   = ~rd_data[7];
                            c_d.ph   = PH_TX;
                        end else begin
                            c_d.oe   = 1'b0;
                            c_d.ph   = PH_RX;
                            c_d.kind = (c_q.kind == K_DEV) ? K_WORD : K_DATA;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (c_q.cnt == 3'd7) begin
                            c_d.oe = 1'b0;
                            c_d.ph = PH_ACK_IN;
                        end else begin
                            c_d.tx  = {c_q.tx[6:0], 1'b0};
                            c_d.oe  = ~c_q.tx[6];
                            c_d.cnt = c_q.cnt + 3'd1;
                        end
                    end
                end
                PH_ACK_IN: begin
                    if (scl_rise) begin
                        c_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (c_q.mack) begin
                            c_d.tx   = rd_data;
                            c_d.addr = c_q.addr + 1'b1;
                            c_d.oe   = ~rd_data[7];
                            c_d.cnt  = '0;
                            c_d.ph   = PH_TX;
                        end else begin
                            c_d.ph = PH_IDLE;
                        end
                    end
                end
                default: begin
                    c_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{ph: PH_IDLE, kind: K_DEV, cnt: '0, full: 1'b0, sh: '0,
                     tx: '0, addr: '0, hi: 1'b0, rd: 1'b0, mack: 1'b0, oe: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign mem_addr  = c_q.addr;
    assign mem_wdata = c_q.sh;
    assign sda_oe    = c_q.oe;
    assign phase     = c_q.ph;

endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target
    import sm_pkg::*;
#(
    parameter int MEM_BYTES   = 512,
    parameter int PAGE_BYTES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic [2:0] addr_pins,
    input  logic       wr_lock
);
    localparam int AW        = $clog2(MEM_BYTES);
    localparam int PAGE_BITS = $clog2(PAGE_BYTES);

    logic          scl_s;
    logic          sda_s;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_evt;
    logic          stop_evt;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;
    phase_e        phase;

    sm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    sm_ctrl #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .addr_pins (addr_pins),
        .wr_lock   (wr_lock),
        .rd_data   (mem_rdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .sda_oe    (sda_oe),
        .phase     (phase)
    );

    sm_store #(.AW(AW), .DW(8)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/sm_checks.sv
module sm_checks
    import sm_pkg::*;
#(
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_in,
    input logic          sda_oe,
    input logic          start_evt,
    input logic          stop_evt,
    input logic          mem_we,
    input logic [AW-1:0] mem_waddr,
    input logic          wr_lock,
    input phase_e        phase
);

    assert_oe_moves_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_in);

    assert_stop_frees_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

    assert_start_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (!sda_oe && phase == PH_RX));

    assert_lock_blocks_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !(wr_lock && mem_waddr[AW-1]));

    assert_idle_off_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_oe);

endmodule

bind serial_mem_target sm_checks #(.AW(AW)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_oe    (sda_oe),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .mem_we    (mem_we),
    .mem_waddr (mem_addr),
    .wr_lock   (wr_lock),
    .phase     (phase)
);

// File: tb/test_serial_mem_target.sv
`timescale 1ns/1ps
module test_serial_mem_target;

    localparam int         Q    = 8;
    localparam logic [2:0] PINS = 3'b101;

    typedef struct packed {
        logic [8:0] a;
        logic [7:0] d;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{9'h000, 8'hC3},
        '{9'h1FF, 8'h3C},
        '{9'h0A5, 8'h5A},
        '{9'h042, 8'h81},
        '{9'h1A0, 8'hE7},
        '{9'h0FF, 8'h96}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl;
    logic       sda_m;
    logic       sda_oe;
    logic [2:0] pins;
    logic       lock;
    wire        sda_bus = sda_m & ~sda_oe;

    int n_chk  = 0;
    int n_bad  = 0;
    int n_viol = 0;
    logic oe_prev = 1'b0;

    always #10 clk = ~clk;

    serial_mem_target i_serial_mem_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl),
        .sda_in    (sda_bus),
        .sda_oe    (sda_oe),
        .addr_pins (pins),
        .wr_lock   (lock)
    );

    // R3: the bus enable may only move while SCL is low
    always @(posedge clk) begin
        #1;
        if (rst_n === 1'b1 && sda_oe !== oe_prev && scl === 1'b1) n_viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl   = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl   = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl   = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            scl = 1'b1; wq(); wq();
            scl = 1'b0; wq();
        end
        sda_m = 1'b1; wq();
        scl = 1'b1; wq();
        acked = !sda_bus; wq();
        scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            scl = 1'b1; wq();
            b[i] = sda_bus; wq();
            scl = 1'b0;
        end
        sda_m = ~mack; wq();
        scl = 1'b1; wq(); wq();
        scl = 1'b0;
        sda_m = 1'b1; wq();
    endtask

    function automatic logic [7:0] dev(input logic rw, input logic a8);
        return {4'hA, PINS[2:1], a8, rw};
    endfunction

    task automatic set_addr(input logic [8:0] a, output logic ok);
        logic k1, k2;
        bus_start();
        send_byte(dev(1'b0, a[8]), k1);
        send_byte(a[7:0], k2);
        ok = k1 & k2;
    endtask

    task automatic write_one(input logic [8:0] a, input logic [7:0] d, output logic ok);
        logic k1, k2;
        set_addr(a, k1);
        send_byte(d, k2);
        bus_stop();
        ok = k1 & k2;
    endtask

    task automatic read_at(input logic [8:0] a, output logic [7:0] d);
        logic k1, k2;
        set_addr(a, k1);
        bus_start();
        send_byte(dev(1'b1, 1'b0), k2);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    initial begin
        logic       ok;
        logic [7:0] d;
        rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; pins = PINS; lock = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        chk("R11 oe after reset", 16'(sda_oe), 16'h0);
        read_at(9'h1C0, d);
        chk("R11 unwritten byte", 16'(d), 16'h00);

        // table walk: byte writes, then random reads (R4, R9)
        for (int i = 0; i < 6; i++) begin
            write_one(VEC[i].a, VEC[i].d, ok);
            chk("R3 ack on write", 16'(ok), 16'h1);
        end
        for (int i = 0; i < 6; i++) begin
            read_at(VEC[i].a, d);
            chk("R4 R9 readback", 16'(d), 16'(VEC[i].d));
        end

        // R2: address byte slot supplies memory bit 8
        write_one(9'h105, 8'h44, ok);
        write_one(9'h005, 8'h22, ok);
        read_at(9'h105, d);
        chk("R2 high half byte", 16'(d), 16'h44);
        read_at(9'h005, d);
        chk("R2 low half byte", 16'(d), 16'h22);

        // R1: mismatched pins and nibble get no acknowledge
        bus_start();
        send_byte({4'hA, ~PINS[2:1], 2'b00}, ok);
        chk("R1 wrong pins no ack", 16'(ok), 16'h0);
        send_byte(8'h00, ok);
        chk("R1 stays off bus", 16'(ok), 16'h0);
        bus_stop();
        bus_start();
        send_byte({4'hB, PINS[2:1], 2'b00}, ok);
        chk("R1 wrong nibble no ack", 16'(ok), 16'h0);
        bus_stop();

        // R5: page write wraps inside the page
        write_one(9'h040, 8'h5E, ok);
        set_addr(9'h03E, ok);
        send_byte(8'hA1, ok);
        send_byte(8'hA2, ok);
        send_byte(8'hA3, ok);
        chk("R3 ack page byte", 16'(ok), 16'h1);
        bus_stop();

        // R7: sequential read then current-address read
        set_addr(9'h03E, ok);
        bus_start();
        send_byte(dev(1'b1, 1'b0), ok);
        recv_byte(1'b1, d);
        chk("R7 seq byte 0", 16'(d), 16'hA1);
        recv_byte(1'b0, d);
        chk("R7 seq byte 1", 16'(d), 16'hA2);
        bus_stop();
        chk("R10 released after nack stop", 16'(sda_oe), 16'h0);
        bus_start();
        send_byte(dev(1'b1, 1'b0), ok);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R7 current address read", 16'(d), 16'h5E);

        read_at(9'h030, d);
        chk("R5 wrapped to page start", 16'(d), 16'hA3);
        read_at(9'h040, d);
        chk("R5 next page untouched", 16'(d), 16'h5E);

        // R8: read wrap from last byte to 0
        set_addr(9'h1FF, ok);
        bus_start();
        send_byte(dev(1'b1, 1'b0), ok);
        recv_byte(1'b1, d);
        chk("R8 last byte", 16'(d), 16'h3C);
        recv_byte(1'b0, d);
        chk("R8 wrapped to zero", 16'(d), 16'hC3);
        bus_stop();

        // R6: write lock on upper half
        lock = 1'b1;
        write_one(9'h1A0, 8'h00, ok);
        chk("R6 locked write acked", 16'(ok), 16'h1);
        write_one(9'h080, 8'h6B, ok);
        lock = 1'b0;
        read_at(9'h1A0, d);
        chk("R6 locked byte unchanged", 16'(d), 16'hE7);
        read_at(9'h080, d);
        chk("R6 lower half written", 16'(d), 16'h6B);

        // R10: stop in the middle of a write frees the bus
        set_addr(9'h050, ok);
        bus_stop();
        chk("R10 idle after stop", 16'(sda_oe), 16'h0);

        chk("R3 oe moved with SCL high", 16'(n_viol), 16'h0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule